// File: doc/BRIEF.md
# Cascadable Maskable Interrupt Controller

This block collects interrupt requests from several external lines and presents one pending request, with its vector type, to a small processor core. Each line is first brought into the core clock domain through a two-stage synchronizer. It is then detected as either a level or a rising edge, chosen per line, and gated by a per-line mask. The lowest-numbered unmasked active line wins. The CPU takes the request with a one-cycle acknowledge pulse. This starts a two-cycle acknowledge phase, and in the second cycle of that phase the controller presents the vector type.

Two of the request pins can take other roles. When source 0 is set for cascade, the request-2 pin becomes an active-low acknowledge output for an external controller that serves source 0. When source 1 is set for cascade, the request-3 pin does the same for source 1. A cascaded source gets its vector type from the external device through a type input. In slave mode, the request-3 pin drives this controller's pending request out to an external master controller.

Top module: `icu_top`

## Requirements
- R1: After reset `cpu_irq` and `type_valid` are low, `p2_oe` and `p3_oe` are low, `p2_out` and `p3_out` are high, all sources are masked and all sources are in edge mode.
- R2: A change on `req_in` is seen by detection only after two clock edges. A level request raised before edge k is not pending after edge k, and is pending after edge k+1.
- R3: A masked source never raises `cpu_irq`. A rising edge that arrives while its source is masked stays latched, and it raises `cpu_irq` once the mask bit is cleared.
- R4: Among pending sources, the lowest index wins. An internally served source i presents type `VEC_BASE + i` (default base 8'h40).
- R5: In edge mode a synchronized rising edge latches a request that stays pending after the line falls. The acknowledge of that source clears the latch. A line held high does not retrigger.
- R6: In level mode a source is pending exactly while its synchronized line is high. It is not cleared by an acknowledge, and it is dropped if the line falls before the acknowledge.
- R7: `cpu_ack` while `cpu_irq` is high starts a two-cycle phase. `cpu_irq` is low through the phase, and `type_valid` is high for exactly its second cycle, together with the type. `cpu_ack` while `cpu_irq` is low has no effect.
- R8: With cascade 0 enabled, `p2_oe` is high, `req_in[2]` is ignored, and `p2_out` is low for exactly the two phase cycles when source 0 is acknowledged. Otherwise `p2_out` is high.
- R9: With cascade 1 enabled and slave mode off, `p3_oe` is high, `req_in[3]` is ignored, and `p3_out` is low for exactly the two phase cycles when source 1 is acknowledged. Otherwise `p3_out` is high.
- R10: When a cascaded source is acknowledged, the type shown in the second phase cycle equals `ext_type` in that cycle.
- R11: In slave mode `p3_oe` is high, `p3_out` follows `cpu_irq`, and `req_in[3]` is ignored. Slave mode takes precedence over cascade 1 on that pin.
- R12: Configuration writes with `cfg_we` high take effect at the next edge. Address 0 writes the mask bits (1 = masked). Address 1 writes the mode bits (1 = level). Address 2 writes bit 0 = cascade 0, bit 1 = cascade 1 and bit 2 = slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | N | Asynchronous request lines, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration field select |
| cfg_wdata | input | N | Configuration write data |
| cpu_ack | input | 1 | CPU acknowledge pulse |
| ext_type | input | VW | Vector type from the external cascaded controller |
| cpu_irq | output | 1 | Pending request to the CPU |
| type_valid | output | 1 | Type is valid (second phase cycle) |
| type_out | output | VW | Vector type of the acknowledged source |
| p2_oe | output | 1 | Request-2 pin is driven as an acknowledge output |
| p2_out | output | 1 | Value driven on the request-2 pin |
| p3_oe | output | 1 | Request-3 pin is driven as an output |
| p3_out | output | 1 | Value driven on the request-3 pin |

## Verification
The bench checks synchronizer latency one edge at a time. A design without the second stage would show a level request one cycle early. It acknowledges a source whose line is still high, in both modes. A design that lets level requests clear on acknowledge would lose the repeat request, and one whose edge latch re-arms from a held line would fire again. Requests are raised on a repurposed pin and on a masked source. A design that does not gate repurposed pins, or that drops edges latched while masked, would raise the wrong interrupt or none at all. The cascade tests count the acknowledge-low cycles and compare the type with `ext_type`. A phase that is one cycle short, or an internal vector shown for a cascaded source, is reported.

// File: rtl/icu_pkg.sv
package icu_pkg;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_ONE = 2'd1, PH_TWO = 2'd2} phase_t;
  localparam logic [1:0] CFG_MASK = 2'd0;
  localparam logic [1:0] CFG_MODE = 2'd1;
  localparam logic [1:0] CFG_PINS = 2'd2;
endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end
endmodule

// File: rtl/icu_detect.sv
module icu_detect #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] level,
  input  logic [N-1:0] clr,
  output logic [N-1:0] active
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic prev_q, lat_q;
    logic rise;
    assign rise = req[i] & ~prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        lat_q  <= 1'b0;
      end else begin
        prev_q <= req[i];
        if (level[i]) lat_q <= 1'b0;
        else          lat_q <= (lat_q & ~clr[i]) | rise;
      end
    end
    assign active[i] = level[i] ? req[i] : lat_q;
  end
endmodule

// File: rtl/icu_arbiter.sv
module icu_arbiter #(
  parameter int N  = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] win
);
  function automatic logic [IW-1:0] lowest_set(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  assign any = |pend;
  assign win = lowest_set(pend);
endmodule

// File: rtl/icu_top.sv
module icu_top #(
  parameter int N  = 5,
  parameter int VW = 8,
  parameter logic [VW-1:0] VEC_BASE = 8'h40,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_in,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [N-1:0]  cfg_wdata,
  input  logic          cpu_ack,
  input  logic [VW-1:0] ext_type,
  output logic          cpu_irq,
  output logic          type_valid,
  output logic [VW-1:0] type_out,
  output logic          p2_oe,
  output logic          p2_out,
  output logic          p3_oe,
  output logic          p3_out
);
  import icu_pkg::*;

  function automatic logic [VW-1:0] vec_of(input logic [IW-1:0] idx);
    return VEC_BASE + VW'(idx);
  endfunction

  logic [N-1:0] mask_q, lvl_q;
  logic         casc0_q, casc1_q, slave_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      lvl_q   <= '0;
      casc0_q <= 1'b0;
      casc1_q <= 1'b0;
      slave_q <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        CFG_MASK: mask_q <= cfg_wdata;
        CFG_MODE: lvl_q  <= cfg_wdata;
        CFG_PINS: begin
          casc0_q <= cfg_wdata[0];
          casc1_q <= cfg_wdata[1];
          slave_q <= cfg_wdata[2];
        end
        default: ;
      endcase
    end
  end

  logic [N-1:0] req_s, pin_taken, req_g, act, pend, clr_vec;
  logic         pend_any, take;
  logic [IW-1:0] win_idx, win_q;
  phase_t       ph_q;

  icu_sync #(.W(N)) u_sync (.clk(clk), .rst_n(rst_n), .d(req_in), .q(req_s));

  always_comb begin
    pin_taken    = '0;
    pin_taken[2] = casc0_q;
    pin_taken[3] = casc1_q | slave_q;
  end

  assign req_g = req_s & ~pin_taken;

  icu_detect #(.N(N)) u_det (
    .clk(clk), .rst_n(rst_n), .req(req_g), .level(lvl_q), .clr(clr_vec), .active(act)
  );

  assign pend = act & ~mask_q & ~pin_taken;

  icu_arbiter #(.N(N)) u_arb (.pend(pend), .any(pend_any), .win(win_idx));

  assign take    = cpu_ack & pend_any & (ph_q == PH_IDLE);
  assign clr_vec = take ? (N'(1) << win_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      win_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (take) begin
          ph_q  <= PH_ONE;
          win_q <= win_idx;
        end
        PH_ONE:  ph_q <= PH_TWO;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  logic in_phase, casc_win0, casc_win1, casc_sel, ack0_n, ack1_n;
  assign in_phase  = (ph_q != PH_IDLE);
  assign casc_win0 = (win_q == '0) && casc0_q;
  assign casc_win1 = (win_q == IW'(1)) && casc1_q && !slave_q;
  assign casc_sel  = casc_win0 | casc_win1;
  assign ack0_n    = !(in_phase && casc_win0);
  assign ack1_n    = !(in_phase && casc_win1);

  assign cpu_irq    = pend_any && !in_phase;
  assign type_valid = (ph_q == PH_TWO);
  assign type_out   = casc_sel ? ext_type : vec_of(win_q);

  assign p2_oe  = casc0_q;
  assign p2_out = casc0_q ? ack0_n : 1'b1;
  assign p3_oe  = casc1_q | slave_q;
  assign p3_out = slave_q ? cpu_irq : (casc1_q ? ack1_n : 1'b1);
endmodule

// File: rtl/icu_checks.sv
module icu_checks #(
  parameter int N  = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input icu_pkg::phase_t ph_q,
  input logic            cpu_irq,
  input logic            type_valid,
  input logic            ack0_n,
  input logic            ack1_n,
  input logic [N-1:0]    pend,
  input logic [N-1:0]    mask_q,
  input logic [IW-1:0]   win_idx
);
  import icu_pkg::*;

  p_quiet_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE) |-> !cpu_irq);

  p_type_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    type_valid |=> !type_valid);

  p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> !mask_q[win_idx]);

  p_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> ((pend & ((N'(1) << win_idx) - N'(1))) == '0));

  p_ack0_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack0_n) |=> !ack0_n);

  p_ack0_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack0_n && $past(!ack0_n)) |=> ack0_n);

  p_ack1_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack1_n) |=> !ack1_n);

  p_ack1_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack1_n && $past(!ack1_n)) |=> ack1_n);
endmodule

bind icu_top icu_checks #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .ph_q(ph_q), .cpu_irq(cpu_irq), .type_valid(type_valid),
  .ack0_n(ack0_n), .ack1_n(ack1_n), .pend(pend), .mask_q(mask_q), .win_idx(win_idx)
);

// File: tb/tb_icu_top.sv
`timescale 1ns/1ps
module tb_icu_top;
  localparam int N  = 5;
  localparam int VW = 8;
  localparam logic [VW-1:0] BASE = 8'h40;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req_in = '0;
  logic cfg_we = 0;
  logic [1:0] cfg_addr = '0;
  logic [N-1:0] cfg_wdata = '0;
  logic cpu_ack = 0;
  logic [VW-1:0] ext_type = '0;
  logic cpu_irq, type_valid, p2_oe, p2_out, p3_oe, p3_out;
  logic [VW-1:0] type_out;

  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  icu_top #(.N(N), .VW(VW), .VEC_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cpu_ack(cpu_ack), .ext_type(ext_type), .cpu_irq(cpu_irq),
    .type_valid(type_valid), .type_out(type_out), .p2_oe(p2_oe), .p2_out(p2_out),
    .p3_oe(p3_oe), .p3_out(p3_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk);
    req_in = req_in | m;
    waitn(2);
    req_in = req_in & ~m;
    waitn(4);
  endtask

  // acknowledge and follow the two-cycle phase; low2/low3: pin expected low
  task automatic ack_seq(input string tag, input logic [VW-1:0] exp_type,
                         input logic low2, input logic low3);
    @(negedge clk);
    cpu_ack = 1;
    @(negedge clk);
    cpu_ack = 0;
    chk({tag, " R7 phase1 irq"}, cpu_irq, 0);
    chk({tag, " R7 phase1 valid"}, type_valid, 0);
    chk({tag, " R8 phase1 p2"}, p2_out, !low2);
    chk({tag, " R9 phase1 p3"}, p3_out, !low3);
    @(negedge clk);
    chk({tag, " R7 phase2 valid"}, type_valid, 1);
    chk({tag, " R4/R10 type"}, type_out, exp_type);
    chk({tag, " R8 phase2 p2"}, p2_out, !low2);
    chk({tag, " R9 phase2 p3"}, p3_out, !low3);
    @(negedge clk);
    chk({tag, " R7 after valid"}, type_valid, 0);
    chk({tag, " R8 after p2"}, p2_out, 1);
    chk({tag, " R9 after p3"}, p3_out, 1);
  endtask

  task automatic t_reset();
    chk("R1 irq", cpu_irq, 0);
    chk("R1 valid", type_valid, 0);
    chk("R1 p2_oe", p2_oe, 0);
    chk("R1 p3_oe", p3_oe, 0);
    chk("R1 p2_out", p2_out, 1);
    chk("R1 p3_out", p3_out, 1);
    pulse(5'b10000);
    chk("R1 masked by default", cpu_irq, 0);
    wr(2'd0, 5'b01111);
    chk("R1 edge by default (latched while masked)", cpu_irq, 1);
    ack_seq("R1", BASE + 8'd4, 0, 0);
    wr(2'd0, '1);
  endtask

  task automatic t_level();
    wr(2'd0, '0);
    wr(2'd1, 5'b10000);
    @(negedge clk);
    req_in[4] = 1;
    @(negedge clk);
    chk("R2 not after one edge", cpu_irq, 0);
    @(negedge clk);
    chk("R2 pending after two edges", cpu_irq, 1);
    ack_seq("R6 level", BASE + 8'd4, 0, 0);
    chk("R6 still pending after ack", cpu_irq, 1);
    req_in[4] = 0;
    waitn(3);
    chk("R6 dropped when line falls", cpu_irq, 0);
  endtask

  task automatic t_edge();
    wr(2'd1, '0);
    pulse(5'b00010);
    chk("R5 latched after line fell", cpu_irq, 1);
    ack_seq("R5 edge", BASE + 8'd1, 0, 0);
    chk("R5 cleared by ack", cpu_irq, 0);
    @(negedge clk);
    req_in[1] = 1;
    waitn(4);
    chk("R5 held line pending", cpu_irq, 1);
    ack_seq("R5 held", BASE + 8'd1, 0, 0);
    waitn(3);
    chk("R5 no retrigger while held", cpu_irq, 0);
    req_in[1] = 0;
    waitn(3);
  endtask

  task automatic t_mask();
    wr(2'd0, 5'b00001);
    pulse(5'b00001);
    chk("R3 masked source quiet", cpu_irq, 0);
    wr(2'd0, '0);
    chk("R3 unmask raises latched edge", cpu_irq, 1);
    ack_seq("R3", BASE, 0, 0);
    chk("R3 cleared", cpu_irq, 0);
  endtask

  task automatic t_prio();
    pulse(5'b01010);
    ack_seq("R4 first", BASE + 8'd1, 0, 0);
    chk("R4 second still pending", cpu_irq, 1);
    ack_seq("R4 second", BASE + 8'd3, 0, 0);
    chk("R4 none left", cpu_irq, 0);
  endtask

  task automatic t_cascade0();
    wr(2'd2, 5'b00001);
    wr(2'd1, 5'b00100);
    chk("R8 p2_oe", p2_oe, 1);
    chk("R8 p2 idle high", p2_out, 1);
    @(negedge clk);
    req_in[2] = 1;
    waitn(4);
    chk("R8 req2 ignored", cpu_irq, 0);
    ext_type = 8'h9A;
    pulse(5'b00001);
    chk("R8 source0 pending", cpu_irq, 1);
    ack_seq("R10 casc0", 8'h9A, 1, 0);
    req_in[2] = 0;
    wr(2'd2, '0);
    chk("R12 cascade0 off", p2_oe, 0);
    waitn(3);
    chk("R8 no stale req2", cpu_irq, 0);
  endtask

  task automatic t_cascade1();
    wr(2'd1, '0);
    wr(2'd2, 5'b00010);
    chk("R9 p3_oe", p3_oe, 1);
    chk("R9 p3 idle high", p3_out, 1);
    ext_type = 8'h5C;
    pulse(5'b00010);
    ack_seq("R9 casc1", 8'h5C, 0, 1);
    pulse(5'b00001);
    ack_seq("R9 internal winner", BASE, 0, 0);
  endtask

  task automatic t_slave();
    wr(2'd1, 5'b11000);
    wr(2'd2, 5'b00110);
    chk("R11 p3_oe", p3_oe, 1);
    chk("R11 p3 follows idle", p3_out, 0);
    @(negedge clk);
    req_in[3] = 1;
    waitn(4);
    chk("R11 req3 ignored", cpu_irq, 0);
    chk("R11 p3 still low", p3_out, 0);
    req_in[4] = 1;
    waitn(3);
    chk("R11 irq", cpu_irq, 1);
    chk("R11 p3 follows irq", p3_out, 1);
    req_in[4] = 0;
    waitn(3);
    chk("R11 p3 drops", p3_out, 0);
    @(negedge clk);
    cpu_ack = 1;
    @(negedge clk);
    cpu_ack = 0;
    chk("R7 stray ack no phase", type_valid, 0);
    @(negedge clk);
    chk("R7 stray ack no type", type_valid, 0);
    chk("R7 stray ack irq", cpu_irq, 0);
    req_in[3] = 0;
  endtask

  initial begin
    waitn(3);
    rst_n = 1;
    waitn(2);
    t_reset();
    t_level();
    t_edge();
    t_mask();
    t_prio();
    t_cascade0();
    t_cascade1();
    t_slave();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule